// File: doc/BRIEF.md
# Configurable asynchronous serial transceiver

A full-duplex serial transceiver that sends and receives asynchronous frames. It is controlled through a byte-wide register port with four addresses. A control register selects the frame length (8 or 9 data bits), the parity mode, how the receiver leaves mute mode, and the interrupt enables. A low-power disable bit stops the baud prescaler and holds the serial output idle. The disable only takes effect once the frame in flight has finished. A transmit holding register feeds the transmitter. A receive holding register collects the frames that are accepted.

Every format setting is captured when a frame starts, so a mid-frame write only affects the next frame. The receiver samples the line at 16 times the bit rate and takes a majority of three samples at mid-bit. It can be put into mute mode, where frames are discarded. Mute ends either after a full frame time of idle line, or on a frame whose most significant bit is 1. One interrupt line combines "transmit holding register empty" with "parity error", each gated by its own enable bit.

Top module: `sci_xcvr`

## Requirements
- R1: After reset the control register (address 0) reads 0x00, the status register (address 1) reads 0x01, tx_o is high and irq_o is low. Control bits are: 0 disable, 1 nine-bit frame, 2 address-mark wake, 3 parity enable, 4 odd parity, 5 parity interrupt enable, 6 transmit interrupt enable, 7 mute. Status bits are: 0 transmit holding register empty, 1 receive data ready, 2 parity error, 3 framing error. Status bits 2 and 3 are cleared by writing 1 to them.
- R2: With bit 1 clear, a frame is one low start bit, then 8 data bits sent least significant bit first, then one high stop bit, each lasting 16 prescaler ticks. Writing address 2 queues a byte. Reading address 2 returns the received byte and clears receive data ready.
- R3: With bit 1 set, a frame carries 9 data bits. The ninth bit is written and read at bit 0 of address 3.
- R4: With parity enabled, the parity bit replaces the top data bit (bit 7 in 8-bit frames, bit 8 in 9-bit frames). It makes the count of ones over the data bits even when bit 4 is 0 and odd when bit 4 is 1. A frame with matching parity does not set the parity error flag.
- R5: A received frame whose parity does not match sets the parity error flag. irq_o rises for that flag only when bit 5 is set.
- R6: A stop bit sampled low sets the framing error flag. The frame is still delivered.
- R7: Changes to the frame length and the parity settings take effect only from the next frame, on both transmit and receive.
- R8: Setting the disable bit lets the frame in progress finish. After that no new frame starts and tx_o stays high. Clearing the bit sends the byte that is pending.
- R9: irq_o is high whenever the transmit holding register is empty and bit 6 is set. A byte that is waiting behind a busy transmitter keeps the flag low.
- R10: In mute mode with address-mark wake, frames whose top data bit is 0 are discarded. A frame whose top data bit is 1 is delivered and clears the mute bit.
- R11: In mute mode with idle-line wake, frames are discarded. The mute bit clears after the line has stayed high for one full frame time (10 or 11 bit times).
- R12: A low pulse on the receive line that does not last to mid-bit (by majority of three samples) starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (read side effects) |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i |
| rx_i | input | 1 | Serial receive line |
| tx_o | output | 1 | Serial transmit line |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is a control change that lands inside a frame: a parity-sense flip, or the disable bit, written while both the transmitter and the receiver are part-way through a frame. The bench loops tx_o back to rx_i, queues a byte, and writes the control register a fixed number of cycles after the start bit. It then checks that the byte in flight arrives with the old settings and that the next byte follows the new ones. The mute wake-ups are reached by driving rx_i from the bench with hand-built frames, back-to-back and then followed by a long idle stretch.

// File: rtl/sci_pkg.sv
package sci_pkg;
  // bit 7 .. bit 0
  typedef struct packed {
    logic mute;
    logic tx_ie;
    logic pe_ie;
    logic par_odd;
    logic par_en;
    logic wake_addr;
    logic len9;
    logic off;
  } ctrl_t;

  typedef struct packed {
    logic len9;
    logic par_en;
    logic par_odd;
  } fmt_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;
  localparam logic [1:0] ADDR_EXT  = 2'd3;
endpackage

// File: rtl/sci_baud.sv
module sci_baud #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!run_i)         cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/sci_tx.sv
module sci_tx import sci_pkg::*; #(
  parameter int OVS = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       start_i,
  input  fmt_t       fmt_i,
  input  logic [8:0] word_i,
  output logic       busy_o,
  output logic       tx_o
);
  localparam int SW = $clog2(OVS);
  localparam logic [SW-1:0] SUB_END = SW'(OVS - 1);

  logic [SW-1:0] sub_q;
  logic [3:0]    idx_q;
  logic [10:0]   sh_q;
  logic          busy_q, len9_q;
  logic [8:0]    w;
  logic          par;

  // parity overwrites the top data bit
  always_comb begin
    w = word_i;
    if (fmt_i.len9) begin
      par = ^word_i[7:0] ^ fmt_i.par_odd;
      if (fmt_i.par_en) w[8] = par;
    end else begin
      par = ^word_i[6:0] ^ fmt_i.par_odd;
      if (fmt_i.par_en) w[7] = par;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '1;
      busy_q <= 1'b0;
      len9_q <= 1'b0;
    end else if (start_i && !busy_q) begin
      sh_q   <= fmt_i.len9 ? {1'b1, w, 1'b0} : {2'b11, w[7:0], 1'b0};
      busy_q <= 1'b1;
      sub_q  <= '0;
      idx_q  <= '0;
      len9_q <= fmt_i.len9;
    end else if (busy_q && tick_i) begin
      if (sub_q == SUB_END) begin
        sub_q <= '0;
        if (idx_q == (len9_q ? 4'd10 : 4'd9)) begin
          busy_q <= 1'b0;
        end else begin
          idx_q <= idx_q + 4'd1;
          sh_q  <= {1'b1, sh_q[10:1]};
        end
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign tx_o   = busy_q ? sh_q[0] : 1'b1;
endmodule

// File: rtl/sci_rx.sv
module sci_rx import sci_pkg::*; #(
  parameter int OVS = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rx_i,
  input  fmt_t       fmt_i,
  input  logic       mute_i,
  input  logic       idle_wake_en_i,
  output logic       busy_o,
  output logic       done_o,
  output logic [8:0] word_o,
  output logic       msb_o,
  output logic       perr_o,
  output logic       ferr_o,
  output logic       idle_seen_o
);
  localparam int SW  = $clog2(OVS);
  localparam int MID = OVS / 2;
  localparam int IW  = $clog2(11 * OVS + 1);
  localparam logic [SW-1:0] SUB_END = SW'(OVS - 1);

  logic [1:0]    sync_q;
  logic          rx_s;
  logic [SW-1:0] sub_q;
  logic [3:0]    idx_q, di;
  logic [8:0]    d_q;
  logic          s_a, s_b, maj, px;
  fmt_t          fmt_q;
  logic          busy_q, done_q, msb_q, perr_q, ferr_q;
  logic [8:0]    word_q;
  logic [IW-1:0] idle_q, idle_lim;

  assign rx_s     = sync_q[1];
  assign maj      = (s_a & s_b) | (s_a & rx_s) | (s_b & rx_s);
  assign di       = idx_q - 4'd1;
  assign px       = fmt_q.len9 ? ^d_q : ^d_q[7:0];
  assign idle_lim = fmt_i.len9 ? IW'(11 * OVS) : IW'(10 * OVS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rx_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_q <= '0; idx_q <= '0; d_q <= '0; s_a <= 1'b1; s_b <= 1'b1;
      fmt_q <= '0; busy_q <= 1'b0; done_q <= 1'b0; msb_q <= 1'b0;
      perr_q <= 1'b0; ferr_q <= 1'b0; word_q <= '0; idle_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (tick_i && !rx_s) begin
          busy_q <= 1'b1;
          sub_q  <= '0;
          idx_q  <= '0;
          fmt_q  <= fmt_i;
          idle_q <= '0;
        end else if (!mute_i) begin
          idle_q <= '0;
        end else if (tick_i && idle_q < idle_lim) begin
          idle_q <= idle_q + 1'b1;
        end
      end else if (tick_i) begin
        if (sub_q == SW'(MID - 1)) s_a <= rx_s;
        if (sub_q == SW'(MID))     s_b <= rx_s;
        if (sub_q == SW'(MID + 1)) begin
          if (idx_q == 4'd0) begin
            if (maj) busy_q <= 1'b0;  // false start
          end else if (idx_q == (fmt_q.len9 ? 4'd10 : 4'd9)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            word_q <= fmt_q.len9 ? d_q : {1'b0, d_q[7:0]};
            msb_q  <= fmt_q.len9 ? d_q[8] : d_q[7];
            perr_q <= fmt_q.par_en && (px != fmt_q.par_odd);
            ferr_q <= !maj;
          end else begin
            d_q[di] <= maj;
          end
        end
        if (sub_q == SUB_END) begin
          sub_q <= '0;
          idx_q <= idx_q + 4'd1;
        end else begin
          sub_q <= sub_q + 1'b1;
        end
      end
    end
  end

  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign word_o      = word_q;
  assign msb_o       = msb_q;
  assign perr_o      = perr_q;
  assign ferr_o      = ferr_q;
  assign idle_seen_o = mute_i && idle_wake_en_i && (idle_q >= idle_lim);
endmodule

// File: rtl/sci_xcvr.sv
module sci_xcvr import sci_pkg::*; #(
  parameter int DIV = 4,
  parameter int OVS = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_wr_i,
  input  logic       reg_rd_i,
  input  logic [1:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  input  logic       rx_i,
  output logic       tx_o,
  output logic       irq_o
);
  ctrl_t      ctrl_q;
  fmt_t       fmt;
  logic [8:0] tdr_q, rdr_q;
  logic       tdre_q, rxne_q, pe_q, fe_q;
  logic       tx_busy, rx_busy, run, tick, tx_start;
  logic       rx_done, rx_msb, rx_perr, rx_ferr, idle_seen;
  logic [8:0] rx_word;
  logic       deliver, mute_clr;
  logic       wr_ctrl, wr_stat, wr_data, wr_ext, rd_data;

  assign wr_ctrl = reg_wr_i && reg_addr_i == ADDR_CTRL;
  assign wr_stat = reg_wr_i && reg_addr_i == ADDR_STAT;
  assign wr_data = reg_wr_i && reg_addr_i == ADDR_DATA;
  assign wr_ext  = reg_wr_i && reg_addr_i == ADDR_EXT;
  assign rd_data = reg_rd_i && reg_addr_i == ADDR_DATA;

  always_comb begin
    fmt.len9    = ctrl_q.len9;
    fmt.par_en  = ctrl_q.par_en;
    fmt.par_odd = ctrl_q.par_odd;
  end

  // disable waits for both directions to go quiet
  assign run      = !(ctrl_q.off && !tx_busy && !rx_busy);
  assign tx_start = !tdre_q && !tx_busy && !ctrl_q.off;
  assign deliver  = rx_done && (!ctrl_q.mute || (ctrl_q.wake_addr && rx_msb));
  assign mute_clr = (ctrl_q.mute && ctrl_q.wake_addr && rx_done && rx_msb) || idle_seen;

  sci_baud #(.DIV(DIV)) i_baud (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .tick_o(tick)
  );

  sci_tx #(.OVS(OVS)) i_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .start_i(tx_start),
    .fmt_i(fmt), .word_i(tdr_q), .busy_o(tx_busy), .tx_o(tx_o)
  );

  sci_rx #(.OVS(OVS)) i_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .rx_i(rx_i), .fmt_i(fmt),
    .mute_i(ctrl_q.mute), .idle_wake_en_i(!ctrl_q.wake_addr), .busy_o(rx_busy),
    .done_o(rx_done), .word_o(rx_word), .msb_o(rx_msb), .perr_o(rx_perr),
    .ferr_o(rx_ferr), .idle_seen_o(idle_seen)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      tdr_q  <= '0;
      tdre_q <= 1'b1;
      rdr_q  <= '0;
      rxne_q <= 1'b0;
      pe_q   <= 1'b0;
      fe_q   <= 1'b0;
    end else begin
      if (wr_ctrl)       ctrl_q      <= ctrl_t'(reg_wdata_i);
      else if (mute_clr) ctrl_q.mute <= 1'b0;

      if (wr_ext) tdr_q[8] <= reg_wdata_i[0];
      if (wr_data) begin
        tdr_q[7:0] <= reg_wdata_i;
        tdre_q     <= 1'b0;
      end else if (tx_start) begin
        tdre_q <= 1'b1;
      end

      if (deliver) begin
        rdr_q  <= rx_word;
        rxne_q <= 1'b1;
      end else if (rd_data) begin
        rxne_q <= 1'b0;
      end

      if (deliver && rx_perr)             pe_q <= 1'b1;
      else if (wr_stat && reg_wdata_i[2]) pe_q <= 1'b0;
      if (deliver && rx_ferr)             fe_q <= 1'b1;
      else if (wr_stat && reg_wdata_i[3]) fe_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      ADDR_CTRL: reg_rdata_o = ctrl_q;
      ADDR_STAT: reg_rdata_o = {4'b0, fe_q, pe_q, rxne_q, tdre_q};
      ADDR_DATA: reg_rdata_o = rdr_q[7:0];
      default:   reg_rdata_o = {7'b0, rdr_q[8]};
    endcase
  end

  assign irq_o = (tdre_q && ctrl_q.tx_ie) || (pe_q && ctrl_q.pe_ie);
endmodule

// File: rtl/sci_xcvr_chk.sv
module sci_xcvr_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_wr_i,
  input logic [1:0] reg_addr_i,
  input logic       tx_o,
  input logic       irq_o,
  input logic       off_i,
  input logic       tx_ie_i,
  input logic       mute_i,
  input logic       tdre_i,
  input logic       rxne_i,
  input logic       tx_busy_i
);
  // R8
  no_start_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_i && !tx_busy_i |=> !tx_busy_i && tx_o);

  // R9
  data_write_fills_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i && reg_addr_i == 2'd2 |=> !tdre_i);

  // R9
  tx_irq_raised_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tdre_i && tx_ie_i |-> irq_o);

  // R10
  no_delivery_muted_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rxne_i) |-> !mute_i);

  // R2
  start_bit_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_o) |-> tx_busy_i);

  // R2
  start_needs_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_busy_i) |-> $past(!tdre_i));
endmodule

bind sci_xcvr sci_xcvr_chk i_sci_xcvr_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
  .tx_o(tx_o), .irq_o(irq_o), .off_i(ctrl_q.off), .tx_ie_i(ctrl_q.tx_ie),
  .mute_i(ctrl_q.mute), .tdre_i(tdre_q), .rxne_i(rxne_q), .tx_busy_i(tx_busy)
);

// File: tb/test_sci_xcvr.sv
`timescale 1ns/1ps
module test_sci_xcvr;
  localparam int BP = 16;  // clocks per bit with DIV=1

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       tx, irq;
  logic       lb = 1'b1, rx_drv = 1'b1;
  logic       rx_line;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  assign rx_line = lb ? tx : rx_drv;
  always #4 clk = ~clk;

  sci_xcvr #(.DIV(1), .OVS(16)) i_sci_xcvr (
    .clk_i(clk), .rst_ni(rst_ni), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .rx_i(rx_line), .tx_o(tx), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wait_rx(input string tag);
    logic [7:0] s;
    s = '0;
    for (int i = 0; i < 1000 && !s[1]; i++) rd(2'd1, s);
    chk(s[1], tag, s, 2);
  endtask

  task automatic send(input logic [10:0] bits, input int n);
    for (int i = 0; i < n; i++) begin
      rx_drv = bits[i];
      repeat (BP) @(negedge clk);
    end
    rx_drv = 1'b1;
  endtask

  task automatic expect_reg(input logic [1:0] a, input logic [7:0] e, input string tag);
    logic [7:0] d;
    rd(a, d);
    chk(d == e, tag, d, e);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, d8;
    logic [8:0] e;
    bit low;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    expect_reg(2'd0, 8'h00, "R1 ctrl");
    expect_reg(2'd1, 8'h01, "R1 status");
    chk(tx == 1'b1, "R1 tx idle", tx, 1);
    chk(irq == 1'b0, "R1 irq", irq, 0);

    // R2 line format of one byte, sampled mid-bit
    wr(2'd2, 8'hA6);
    repeat (9) @(negedge clk);
    for (int b = 0; b < 10; b++) begin
      logic ex;
      ex = (b == 0) ? 1'b0 : (b == 9) ? 1'b1 : 1'((8'hA6 >> (b - 1)) & 1);
      chk(tx == ex, "R2 bit", tx, ex);
      repeat (BP) @(negedge clk);
    end
    wait_rx("R2 rx");
    expect_reg(2'd2, 8'hA6, "R2 data");

    // R2 all byte values round trip
    for (int v = 0; v < 256; v++) begin
      wr(2'd2, 8'(v));
      wait_rx("R2 sweep ready");
      rd(2'd2, d);
      chk(d == 8'(v), "R2 sweep", d, v);
    end

    // R3 nine-bit frames
    wr(2'd0, 8'h02);
    for (int v = 0; v < 512; v += 7) begin
      wr(2'd3, {7'b0, 1'(v >> 8)});
      wr(2'd2, 8'(v));
      wait_rx("R3 ready");
      rd(2'd3, d8);
      rd(2'd2, d);
      chk({d8[0], d} == 9'(v), "R3 sweep", {d8[0], d}, v);
    end

    // R4 parity generation and check, all four formats
    for (int cfg = 0; cfg < 4; cfg++) begin
      logic len9, odd;
      len9 = cfg[0];
      odd  = cfg[1];
      wr(2'd0, {3'b0, odd, 1'b1, 1'b0, len9, 1'b0});
      for (int v = 0; v < 512; v += 13) begin
        if (len9) e = {^v[7:0] ^ odd, v[7:0]};
        else      e = {1'b0, ^v[6:0] ^ odd, v[6:0]};
        wr(2'd3, {7'b0, 1'(v >> 8)});
        wr(2'd2, 8'(v));
        wait_rx("R4 ready");
        rd(2'd3, d8);
        rd(2'd2, d);
        chk({(len9 & d8[0]), d} == e, "R4 word", {d8[0], d}, e);
      end
      expect_reg(2'd1, 8'h01, "R4 no parity error");
    end

    // R7 parity sense changed mid-frame applies to next frame only
    wr(2'd0, 8'h08);
    wr(2'd2, 8'h00);
    repeat (20) @(negedge clk);
    wr(2'd0, 8'h18);
    wait_rx("R7 ready");
    expect_reg(2'd1, 8'h03, "R7 no pe old frame");
    expect_reg(2'd2, 8'h00, "R7 old parity");
    wr(2'd2, 8'h00);
    wait_rx("R7 ready2");
    expect_reg(2'd1, 8'h03, "R7 no pe new frame");
    expect_reg(2'd2, 8'h80, "R7 new parity");

    // R8 disable during a frame
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h5A);
    repeat (2) @(negedge clk);
    wr(2'd0, 8'h01);
    wait_rx("R8 frame finishes");
    expect_reg(2'd2, 8'h5A, "R8 data");
    repeat (20) @(negedge clk);
    wr(2'd2, 8'hA5);
    low = 1'b0;
    repeat (400) begin
      @(negedge clk);
      if (!tx) low = 1'b1;
    end
    chk(!low, "R8 tx held high", low, 0);
    expect_reg(2'd1, 8'h00, "R8 pending not sent");
    wr(2'd0, 8'h00);
    wait_rx("R8 resume");
    expect_reg(2'd2, 8'hA5, "R8 resumed data");

    // R9 transmit interrupt
    wr(2'd0, 8'h40);
    chk(irq == 1'b1, "R9 irq empty", irq, 1);
    wr(2'd2, 8'h11);
    wr(2'd2, 8'h22);
    repeat (10) @(negedge clk);
    chk(irq == 1'b0, "R9 irq while waiting", irq, 0);
    expect_reg(2'd1, 8'h00, "R9 status waiting");
    wait_rx("R9 first");
    expect_reg(2'd2, 8'h11, "R9 first data");
    chk(irq == 1'b1, "R9 irq after load", irq, 1);
    wait_rx("R9 second");
    expect_reg(2'd2, 8'h22, "R9 second data");
    wr(2'd0, 8'h00);
    chk(irq == 1'b0, "R9 irq disabled", irq, 0);

    // R5 parity error from line
    lb = 1'b0;
    wr(2'd0, 8'h28);
    send({1'b1, 8'h01, 1'b0}, 10);
    expect_reg(2'd1, 8'h07, "R5 pe set");
    chk(irq == 1'b1, "R5 irq", irq, 1);
    expect_reg(2'd2, 8'h01, "R5 data");
    wr(2'd1, 8'h04);
    expect_reg(2'd1, 8'h01, "R5 pe cleared");
    chk(irq == 1'b0, "R5 irq cleared", irq, 0);
    send({1'b1, 8'h81, 1'b0}, 10);
    expect_reg(2'd1, 8'h03, "R5 good parity");
    expect_reg(2'd2, 8'h81, "R5 good data");
    wr(2'd0, 8'h08);
    send({1'b1, 8'h01, 1'b0}, 10);
    expect_reg(2'd1, 8'h07, "R5 pe no enable");
    chk(irq == 1'b0, "R5 irq masked", irq, 0);
    wr(2'd1, 8'h04);
    rd(2'd2, d);

    // R6 framing error
    wr(2'd0, 8'h00);
    send({1'b0, 8'h55, 1'b0}, 10);
    repeat (40) @(negedge clk);
    expect_reg(2'd1, 8'h0B, "R6 fe set");
    expect_reg(2'd2, 8'h55, "R6 data");
    wr(2'd1, 8'h08);
    expect_reg(2'd1, 8'h01, "R6 fe cleared");

    // R12 short low glitch
    @(negedge clk); rx_drv = 1'b0;
    repeat (3) @(negedge clk); rx_drv = 1'b1;
    repeat (200) @(negedge clk);
    expect_reg(2'd1, 8'h01, "R12 glitch ignored");

    // R10 address-mark wake
    wr(2'd0, 8'h84);
    send({1'b1, 8'h35, 1'b0}, 10);
    expect_reg(2'd1, 8'h01, "R10 discarded");
    expect_reg(2'd0, 8'h84, "R10 still muted");
    send({1'b1, 8'hB5, 1'b0}, 10);
    expect_reg(2'd1, 8'h03, "R10 delivered");
    expect_reg(2'd0, 8'h04, "R10 unmuted");
    expect_reg(2'd2, 8'hB5, "R10 data");

    // R11 idle-line wake
    wr(2'd0, 8'h80);
    send({1'b1, 8'h3C, 1'b0}, 10);
    send({1'b1, 8'hC3, 1'b0}, 10);
    expect_reg(2'd1, 8'h01, "R11 discarded");
    expect_reg(2'd0, 8'h80, "R11 still muted");
    repeat (200) @(negedge clk);
    expect_reg(2'd0, 8'h00, "R11 woke on idle");
    send({1'b1, 8'h3C, 1'b0}, 10);
    expect_reg(2'd1, 8'h03, "R11 delivered");
    expect_reg(2'd2, 8'h3C, "R11 data");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule